// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block keeps the running state of one DMA channel: the current address, the elements left in the current row, and the rows left in the current work unit. An external data path pulses an element-accepted strobe each time it moves one element. On each strobe the block advances the address by the signed element stride and counts the element off. When a row runs out, the block decides whether to start the next row of a two-dimensional transfer, to reload for a new work unit, or to finish.

The programmed values are plain inputs that a register file owns: start address, row length, row count, element stride, row stride, element width, flow mode, 2D enable and per-row interrupt enable. A pulse on `arm` starts a work unit from those inputs. In autobuffer flow the block starts again from the same inputs on its own. In descriptor flow it asks for a reload and then waits until the descriptor fetcher signals that the inputs hold new values.

Top module: `dma2d_addr_gen`

## Requirements
- R1: A pulse on `arm` loads the current address from `start_addr`, the row count from `x_count` and the row total from `y_count`. A programmed count of zero loads as all ones. The same edge sets `run` and clears `done`.
- R2: An accepted element that is not the last of its row adds the sign-extended `x_mod` to the current address and lowers the current X count by one.
- R3: When `two_d` is 1 and the current Y count is above 1, the last element of a row does not apply `x_mod`. Instead `y_mod` is added to the address (address minus X stride plus Y stride, taken from the address the element would have produced), the X count reloads from `x_count`, and the Y count drops by one.
- R4: With `irq_en` set, `irq` is high for exactly one cycle after the edge that accepts the last element of each row. It is also a single pulse when that row end is the end of the work unit. With `irq_en` clear, `irq` stays low.
- R5: In stop flow (`flow_mode` = 0), the last element of the work unit applies `x_mod`, sets the current X count to 0, clears `run` and sets `done`.
- R6: In autobuffer flow (`flow_mode` = 1), the end of the work unit pulses `reload_req` for one cycle. On the same edge it reinitialises the address and the counts from the programmed inputs, and `run` stays set.
- R7: In descriptor flow (`flow_mode` = 2 or 3), the end of the work unit applies `x_mod` and pulses `reload_req`. Strobes are then ignored until `desc_ready`, which reloads the address and the counts from the inputs.
- R8: `elem_ok` has no effect while `run` is clear.
- R9: At each load, `cfg_err` captures whether the magnitude of `x_mod` differs from the element size, or whether `start_addr` is not a multiple of it. The element size is 1 byte for `elem_size` 0, 2 bytes for 1, and 4 bytes for 2 or 3.
- R10: `burst_max` is 1 while `x_mod` is negative, and otherwise equals the current X count.
- R11: With `two_d` at 0, `y_count` is ignored, and every row end is the end of the work unit.
- R12: After reset, the address, both counts, `run`, `done`, `irq`, `reload_req` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start a work unit from the programmed inputs |
| elem_ok | input | 1 | One element accepted by the data path |
| desc_ready | input | 1 | New descriptor values are present on the inputs |
| flow_mode | input | 2 | 0 stop, 1 autobuffer, 2/3 descriptor |
| two_d | input | 1 | Enable two-dimensional transfer |
| irq_en | input | 1 | Interrupt at each row end |
| elem_size | input | 2 | Element width code |
| start_addr | input | AW | Work unit start address |
| x_count | input | CW | Elements per row |
| x_mod | input | MW | Signed element stride in bytes |
| y_count | input | CW | Rows per work unit |
| y_mod | input | MW | Signed row stride in bytes |
| cur_addr | output | AW | Current address |
| cur_x | output | CW | Elements left in the row |
| cur_y | output | CW | Rows left in the work unit |
| burst_max | output | CW | Elements the data path may move back to back |
| irq | output | 1 | Row-end interrupt pulse |
| reload_req | output | 1 | Reload request pulse |
| run | output | 1 | Channel active |
| done | output | 1 | Work unit finished in stop flow |
| cfg_err | output | 1 | Stride or alignment error at the last load |

## Verification
The embedded properties check on every cycle that the X count falls by one per ordinary element, that the Y count falls at a row step, that `done` and `run` are never both high, that no element is counted while the channel waits for a descriptor, and that the address and counts hold while the channel is idle. Only the bench scenarios can show the arithmetic: the address values across a row step, an interrupt that fires once where a row end meets a work end, reinitialisation in autobuffer flow, reload after `desc_ready`, and the stride and alignment error table.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    typedef enum logic [1:0] {
        FLOW_STOP = 2'd0,
        FLOW_AUTO = 2'd1,
        FLOW_DESC = 2'd2
    } flow_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_WAIT   = 2'd2
    } chan_st_e;

    typedef struct packed {
        logic load;
        logic step;
        logic row_end;
        logic work_end;
    } ctl_s;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma2d_stride_chk.sv
module dma2d_stride_chk #(
    parameter int AW = 32,
    parameter int MW = 16
) (
    input  logic [1:0]    elem_size,
    input  logic [MW-1:0] x_mod,
    input  logic [AW-1:0] start_addr,
    output logic          bad
);
    import dma2d_pkg::*;

    logic [2:0]    nbytes;
    logic [MW-1:0] mag;
    logic          misaligned;

    always_comb begin
        nbytes     = size_bytes(elem_size);
        mag        = x_mod[MW-1] ? (~x_mod + 1'b1) : x_mod;
        misaligned = (start_addr[2:0] & (nbytes - 3'd1)) != 3'd0;
        bad        = (mag != MW'(nbytes)) || misaligned;
    end
endmodule

// File: rtl/dma2d_counters.sv
module dma2d_counters #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          two_d,
    input  logic [CW-1:0] x_prog,
    input  logic [CW-1:0] y_prog,
    output logic [CW-1:0] cur_x,
    output logic [CW-1:0] cur_y,
    output logic          row_last,
    output logic          more_rows
);
    logic [CW-1:0] x_eff, y_eff;

    always_comb begin
        x_eff     = (x_prog == '0) ? '1 : x_prog;
        y_eff     = (y_prog == '0) ? '1 : y_prog;
        row_last  = (cur_x == CW'(1));
        more_rows = two_d && (cur_y > CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_x <= '0;
            cur_y <= '0;
        end else if (load) begin
            cur_x <= x_eff;
            cur_y <= y_eff;
        end else if (step) begin
            if (!row_last) begin
                cur_x <= cur_x - 1'b1;
            end else if (more_rows) begin
                cur_x <= x_eff;
                cur_y <= cur_y - 1'b1;
            end else begin
                cur_x <= '0;
            end
        end
    end

    p_x_dec_r2: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !row_last) |=> (cur_x == $past(cur_x) - 1'b1));

    p_y_dec_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !load && row_last && more_rows) |=> (cur_y == $past(cur_y) - 1'b1));
endmodule

// File: rtl/dma2d_addr.sv
module dma2d_addr #(
    parameter int AW = 32,
    parameter int MW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          row_step,
    input  logic [AW-1:0] start_addr,
    input  logic [MW-1:0] x_mod,
    input  logic [MW-1:0] y_mod,
    output logic [AW-1:0] cur_addr
);
    localparam int EXT = AW - MW;

    logic [AW-1:0] x_ext, y_ext;

    always_comb begin
        x_ext = {{EXT{x_mod[MW-1]}}, x_mod};
        y_ext = {{EXT{y_mod[MW-1]}}, y_mod};
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_addr <= '0;
        else if (load)
            cur_addr <= start_addr;
        else if (row_step)
            cur_addr <= cur_addr + y_ext;
        else if (step)
            cur_addr <= cur_addr + x_ext;
    end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int MW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          elem_ok,
    input  logic          desc_ready,
    input  logic [1:0]    flow_mode,
    input  logic          two_d,
    input  logic          irq_en,
    input  logic [1:0]    elem_size,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] x_count,
    input  logic [MW-1:0] x_mod,
    input  logic [CW-1:0] y_count,
    input  logic [MW-1:0] y_mod,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_x,
    output logic [CW-1:0] cur_y,
    output logic [CW-1:0] burst_max,
    output logic          irq,
    output logic          reload_req,
    output logic          run,
    output logic          done,
    output logic          cfg_err
);
    import dma2d_pkg::*;

    chan_st_e state;
    ctl_s     ctl;
    logic     row_last, more_rows, bad_cfg;

    dma2d_stride_chk #(.AW(AW), .MW(MW)) u_chk (
        .elem_size (elem_size),
        .x_mod     (x_mod),
        .start_addr(start_addr),
        .bad       (bad_cfg)
    );

    dma2d_counters #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .step     (ctl.step),
        .two_d    (two_d),
        .x_prog   (x_count),
        .y_prog   (y_count),
        .cur_x    (cur_x),
        .cur_y    (cur_y),
        .row_last (row_last),
        .more_rows(more_rows)
    );

    dma2d_addr #(.AW(AW), .MW(MW)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.load),
        .step      (ctl.step),
        .row_step  (ctl.row_end && more_rows),
        .start_addr(start_addr),
        .x_mod     (x_mod),
        .y_mod     (y_mod),
        .cur_addr  (cur_addr)
    );

    always_comb begin
        ctl.step     = (state == ST_ACTIVE) && elem_ok && !arm;
        ctl.row_end  = ctl.step && row_last;
        ctl.work_end = ctl.row_end && !more_rows;
        ctl.load     = arm
                    || ((state == ST_WAIT) && desc_ready)
                    || (ctl.work_end && (flow_mode == FLOW_AUTO));
        run          = (state != ST_IDLE);
        burst_max    = x_mod[MW-1] ? CW'(1) : cur_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            done       <= 1'b0;
            irq        <= 1'b0;
            reload_req <= 1'b0;
            cfg_err    <= 1'b0;
        end else begin
            irq        <= ctl.row_end && irq_en;
            reload_req <= ctl.work_end && (flow_mode != FLOW_STOP);
            if (ctl.load)
                cfg_err <= bad_cfg;
            if (arm) begin
                state <= ST_ACTIVE;
                done  <= 1'b0;
            end else if (state == ST_WAIT) begin
                if (desc_ready)
                    state <= ST_ACTIVE;
            end else if (ctl.work_end) begin
                if (flow_mode == FLOW_STOP) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end else if (flow_mode != FLOW_AUTO) begin
                    state <= ST_WAIT;
                end
            end
        end
    end

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !run);

    p_reload_running_r6: assert property (@(posedge clk) disable iff (rst)
        reload_req |-> run);

    p_wait_no_step_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> !ctl.step);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!run && !arm) |=> ($stable(cur_addr) && $stable(cur_x) && $stable(cur_y)));

    p_irq_source_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl.step && row_last && irq_en) |=> irq);
endmodule

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int MW = 16;
    localparam int WATCHDOG = 5000;

    logic          clk = 1'b0;
    logic          rst, arm, elem_ok, desc_ready, two_d, irq_en;
    logic [1:0]    flow_mode, elem_size;
    logic [AW-1:0] start_addr;
    logic [CW-1:0] x_count, y_count;
    logic [MW-1:0] x_mod, y_mod;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_x, cur_y, burst_max;
    logic          irq, reload_req, run, done, cfg_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma2d_addr_gen #(.AW(AW), .CW(CW), .MW(MW)) i_dma2d_addr_gen (
        .clk(clk), .rst(rst), .arm(arm), .elem_ok(elem_ok), .desc_ready(desc_ready),
        .flow_mode(flow_mode), .two_d(two_d), .irq_en(irq_en), .elem_size(elem_size),
        .start_addr(start_addr), .x_count(x_count), .x_mod(x_mod), .y_count(y_count),
        .y_mod(y_mod), .cur_addr(cur_addr), .cur_x(cur_x), .cur_y(cur_y),
        .burst_max(burst_max), .irq(irq), .reload_req(reload_req), .run(run),
        .done(done), .cfg_err(cfg_err)
    );

    // {elem_size, x_mod, start_addr, exp_err, exp_burst}; x_count is 5
    localparam logic [54:0] VEC [6] = '{
        {2'd2, 16'h0004, 32'h0000_0100, 1'b0, 4'd5},
        {2'd2, 16'hFFFC, 32'h0000_0100, 1'b0, 4'd1},
        {2'd1, 16'h0004, 32'h0000_0100, 1'b1, 4'd5},
        {2'd0, 16'h0001, 32'h0000_0101, 1'b0, 4'd5},
        {2'd1, 16'h0002, 32'h0000_0101, 1'b1, 4'd5},
        {2'd3, 16'hFFFC, 32'h0000_0104, 1'b0, 4'd1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_arm();
        arm = 1'b1; tick(); arm = 1'b0;
    endtask

    task automatic accept();
        elem_ok = 1'b1; tick(); elem_ok = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; arm = 0; elem_ok = 0; desc_ready = 0; two_d = 0; irq_en = 0;
        flow_mode = 2'd0; elem_size = 2'd2; start_addr = '0;
        x_count = '0; y_count = '0; x_mod = 16'd4; y_mod = '0;
        @(negedge clk); tick(); tick();
        rst = 1'b0;

        // R12 reset state
        chk("R12 addr", cur_addr, 0);
        chk("R12 cnt", {cur_x, cur_y}, 0);
        chk("R12 flags", {run, done, irq, reload_req, cfg_err}, 0);

        // R9 / R10 table
        x_count = 16'd5;
        foreach (VEC[i]) begin
            elem_size  = VEC[i][54:53];
            x_mod      = VEC[i][52:37];
            start_addr = VEC[i][36:5];
            do_arm();
            chk($sformatf("R9 vec%0d", i), cfg_err, VEC[i][4]);
            chk($sformatf("R10 vec%0d", i), burst_max, CW'(VEC[i][3:0]));
        end

        // Two-dimensional stop flow with row interrupts
        flow_mode = 2'd0; two_d = 1; irq_en = 1; elem_size = 2'd2;
        start_addr = 32'h100; x_count = 3; x_mod = 16'd4; y_count = 2; y_mod = 16'h20;
        do_arm();
        chk("R1 addr", cur_addr, 32'h100);
        chk("R1 counts", {cur_x, cur_y}, {16'd3, 16'd2});
        chk("R1 run/done", {run, done}, 2'b10);
        accept();
        chk("R2 addr", cur_addr, 32'h104);
        chk("R2 x", cur_x, 2);
        accept();
        chk("R2 addr2", cur_addr, 32'h108);
        chk("R4 no irq mid row", irq, 0);
        accept();
        chk("R3 addr", cur_addr, 32'h128);
        chk("R3 counts", {cur_x, cur_y}, {16'd3, 16'd1});
        chk("R4 irq row", irq, 1);
        tick();
        chk("R4 irq one cycle", irq, 0);
        accept(); accept();
        chk("R2 addr row2", cur_addr, 32'h130);
        accept();
        chk("R5 addr", cur_addr, 32'h134);
        chk("R5 run/done", {run, done}, 2'b01);
        chk("R5 x", cur_x, 0);
        chk("R4 irq at end", irq, 1);
        chk("R5 no reload", reload_req, 0);
        tick();
        chk("R4 irq once", irq, 0);
        accept();
        chk("R8 addr idle", cur_addr, 32'h134);
        chk("R8 x idle", cur_x, 0);

        // Zero counts load as all ones; irq disabled
        x_count = 0; y_count = 0; irq_en = 0;
        do_arm();
        chk("R1 zero count", {cur_x, cur_y}, {16'hFFFF, 16'hFFFF});
        x_count = 1; y_count = 2;
        do_arm();
        accept();
        chk("R4 irq disabled", irq, 0);
        chk("R3 row step", cur_addr, 32'h120);

        // Autobuffer, 1D, negative stride, y ignored
        flow_mode = 2'd1; two_d = 0; elem_size = 2'd0;
        start_addr = 32'h200; x_count = 2; x_mod = 16'hFFFF; y_count = 5;
        do_arm();
        chk("R10 negative", burst_max, 1);
        accept();
        chk("R2 negative", cur_addr, 32'h1FF);
        accept();
        chk("R6 reload pulse", reload_req, 1);
        chk("R6 reinit", {cur_addr, cur_x}, {32'h200, 16'd2});
        chk("R11 y ignored", run, 1);
        tick();
        chk("R6 pulse one cycle", reload_req, 0);

        // Descriptor flow
        flow_mode = 2'd2; elem_size = 2'd1; irq_en = 1;
        start_addr = 32'h300; x_count = 1; x_mod = 16'd2;
        do_arm();
        accept();
        chk("R7 reload", reload_req, 1);
        chk("R7 addr", cur_addr, 32'h302);
        chk("R11 irq 1D", irq, 1);
        accept();
        chk("R7 wait ignore", cur_addr, 32'h302);
        chk("R7 wait run", run, 1);
        start_addr = 32'h400; x_count = 2;
        desc_ready = 1; tick(); desc_ready = 0;
        chk("R7 loaded", {cur_addr, cur_x}, {32'h400, 16'd2});
        accept();
        chk("R7 resumed", cur_addr, 32'h402);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule